// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block is the processor-facing register file of a small serial port, attached to an 8-bit bus. A 5-bit address inside a 32-byte chip-select window reaches eight register slots. Only the low three address bits are decoded, so every slot appears four times in the window. The serial shifter sits outside the block. It delivers received bytes through a valid/data pair and takes transmit bytes through a one-cycle load pulse.

Some slots change internal state when they are only read. Reading the receive data slot drops the byte-waiting flag. Reading the command slot swaps the active rate table. Reading the auxiliary command slot enters or leaves a test mode, in which the block stops accepting received bytes and stops issuing transmit loads. The block outputs the rate chosen from the active table, the table select, the test-mode flag and the byte-waiting flag. Software that scans memory, and CPUs that issue dummy reads during indexed stores, can flip these modes, so each side effect is defined exactly here.

Slot map, indexed by `addr[2:0]`:

| Slot | Read | Write |
|------|------|-------|
| 0 | status | rate code (bits 3:0) |
| 1 | rate code, and swaps the rate table | command register |
| 2 | received byte, and clears the byte-waiting flag | transmit byte |
| 3 | auxiliary command register, and toggles test mode | auxiliary command register |
| 4 | command register | ignored |
| 5 to 7 | 0x00 | ignored |

Top module: `uart_regfile`

## Requirements
- R1: Only `addr[2:0]` selects a slot, so `addr[4:3]` has no effect. With `cs` low, neither `rd` nor `wr` has any effect.
- R2: A read or a write acts once, in the first cycle in which `cs` and its strobe are both high. Holding the strobe high for more cycles causes no further action.
- R3: A read of slot 1 inverts `alt_baud` and returns the rate code in bits 3:0. A write to slot 1 stores the command register and leaves `alt_baud` unchanged.
- R4: `rate_bps` is the table entry for the rate code, registered one cycle after a change. Code 12 gives 9600 in the primary table and 28800 in the alternate table. Code 14 gives 19200 and code 15 gives 38400 in both tables. Code 0 gives 50 in the primary table.
- R5: A read of slot 3 inverts `test_mode` and returns the auxiliary command register. A write to slot 3 updates that register and leaves `test_mode` unchanged.
- R6: While `test_mode` is 1, `rx_valid` is ignored, and a write to slot 2 produces no `tx_load` pulse.
- R7: Outside test mode, a write to slot 2 pulses `tx_load` for one cycle, with the written byte on `tx_data`.
- R8: A read of slot 2 returns the held received byte and clears `rx_ready` and the overrun flag. If a byte arrives in the same cycle, the read returns the older byte and `rx_ready` stays 1.
- R9: A byte that arrives while `rx_ready` is 1 replaces the held byte and sets the overrun flag.
- R10: The status read returns `rx_ready` in bit 0, overrun in bit 1, `alt_baud` in bit 2 and `test_mode` in bit 3. Bits 7:4 are 0.
- R11: A synchronous `rst` clears `alt_baud`, `test_mode`, `rx_ready`, overrun, `tx_load` and all registers.
- R12: A read of slot 4 returns the command register. Reads of slots 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the 32-byte window |
| addr | input | 5 | Byte address within the window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte strobe from the shifter |
| rx_data | input | 8 | Received byte |
| tx_load | output | 1 | One-cycle transmit load pulse |
| tx_data | output | 8 | Transmit byte |
| alt_baud | output | 1 | Alternate rate table active |
| test_mode | output | 1 | Test mode active |
| rx_ready | output | 1 | A received byte is waiting |
| rate_bps | output | 16 | Selected rate in bits per second |

## Verification
The bench reaches each toggling slot through mirror addresses. It holds a read strobe for several cycles, which catches a design that toggles on the level rather than the edge: such a design would flip the table once per cycle and could land back on its start value. It writes the slots that toggle on a read and checks that both toggles stay put, and it checks that the shared 19200 and 38400 entries match in both tables while code 12 differs. It also sets up a read of the data slot and a byte arrival in the same cycle. A design that let the clear win would lose the new byte and report the port empty.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

  localparam int SLOT_W    = 3;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int RATE_W    = 16;

  localparam logic [SLOT_W-1:0] SLOT_STATUS  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_BAUDTGL = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_DATA    = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_TESTTGL = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_CMDRB   = 3'd4;

  localparam int ST_RXRDY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_ALT   = 2;
  localparam int ST_TEST  = 3;

  // Toggle bank indices
  localparam int TG_ALT  = 0;
  localparam int TG_TEST = 1;
  localparam int NUM_TG  = 2;

  function automatic logic [RATE_W-1:0] rate_lookup(input logic alt, input logic [3:0] code);
    logic [RATE_W-1:0] r;
    if (!alt) begin
      case (code)
        4'd0:  r = 16'd50;
        4'd1:  r = 16'd75;
        4'd2:  r = 16'd110;
        4'd3:  r = 16'd150;
        4'd4:  r = 16'd300;
        4'd5:  r = 16'd600;
        4'd6:  r = 16'd1200;
        4'd7:  r = 16'd1800;
        4'd8:  r = 16'd2400;
        4'd9:  r = 16'd3600;
        4'd10: r = 16'd4800;
        4'd11: r = 16'd7200;
        4'd12: r = 16'd9600;
        4'd13: r = 16'd14400;
        4'd14: r = 16'd19200;
        default: r = 16'd38400;
      endcase
    end else begin
      case (code)
        4'd0:  r = 16'd75;
        4'd1:  r = 16'd110;
        4'd2:  r = 16'd134;
        4'd3:  r = 16'd200;
        4'd4:  r = 16'd300;
        4'd5:  r = 16'd600;
        4'd6:  r = 16'd1200;
        4'd7:  r = 16'd1050;
        4'd8:  r = 16'd2400;
        4'd9:  r = 16'd4800;
        4'd10: r = 16'd7200;
        4'd11: r = 16'd9600;
        4'd12: r = 16'd28800;
        4'd13: r = 16'd57600;
        4'd14: r = 16'd19200;
        default: r = 16'd38400;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/uart_bus_strobe.sv
module uart_bus_strobe #(
  parameter int ADDR_W    = 5,
  parameter int SLOT_W    = 3,
  parameter int NUM_SLOTS = 1 << SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic                 rd_any,
  output logic [SLOT_W-1:0]    slot,
  output logic [NUM_SLOTS-1:0] rd_hit,
  output logic [NUM_SLOTS-1:0] wr_hit
);
  logic rd_q, wr_q;
  logic rd_lvl, wr_lvl, wr_any;

  assign rd_lvl = cs & rd;
  assign wr_lvl = cs & wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_lvl;
      wr_q <= wr_lvl;
    end
  end

  assign rd_any = rd_lvl & ~rd_q;
  assign wr_any = wr_lvl & ~wr_q;
  assign slot   = addr[SLOT_W-1:0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign rd_hit[i] = rd_any & (slot == SLOT_W'(i));
    assign wr_hit[i] = wr_any & (slot == SLOT_W'(i));
  end
endmodule

// File: rtl/uart_mode_toggles.sv
module uart_mode_toggles #(
  parameter int NUM_TG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_TG-1:0] flip,
  output logic [NUM_TG-1:0] state
);
  for (genvar i = 0; i < NUM_TG; i++) begin : g_tg
    always_ff @(posedge clk) begin
      if (rst)          state[i] <= 1'b0;
      else if (flip[i]) state[i] <= ~state[i];
    end
  end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          accept_en,
  input  logic          clear,
  output logic          ready,
  output logic          overrun,
  output logic [DW-1:0] hold
);
  logic push;
  assign push = rx_valid & accept_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      overrun <= 1'b0;
      hold    <= '0;
    end else begin
      if (push) begin
        hold    <= rx_data;
        ready   <= 1'b1;
        overrun <= (ready & ~clear) | (overrun & ~clear);
      end else if (clear) begin
        ready   <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rate_select.sv
module uart_rate_select
  import uart_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              alt,
  input  logic [3:0]        code,
  output logic [RATE_W-1:0] rate_bps
);
  always_ff @(posedge clk) begin
    if (rst) rate_bps <= rate_lookup(1'b0, 4'd0);
    else     rate_bps <= rate_lookup(alt, code);
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  output logic              tx_load,
  output logic [DW-1:0]     tx_data,
  output logic              alt_baud,
  output logic              test_mode,
  output logic              rx_ready,
  output logic [RATE_W-1:0] rate_bps
);
  logic                 rd_any;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_SLOTS-1:0] rd_hit, wr_hit;
  logic [NUM_TG-1:0]    tg_flip, tg_state;
  logic                 overrun;
  logic [DW-1:0]        rx_hold;
  logic [3:0]           rate_code;
  logic [DW-1:0]        cmd_reg, aux_reg;
  logic [DW-1:0]        status;

  uart_bus_strobe #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_strobe (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .rd_any(rd_any), .slot(slot), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  assign tg_flip[TG_ALT]  = rd_hit[SLOT_BAUDTGL];
  assign tg_flip[TG_TEST] = rd_hit[SLOT_TESTTGL];

  uart_mode_toggles #(.NUM_TG(NUM_TG)) u_toggles (
    .clk(clk), .rst(rst), .flip(tg_flip), .state(tg_state)
  );

  assign alt_baud  = tg_state[TG_ALT];
  assign test_mode = tg_state[TG_TEST];

  uart_rx_holding #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .accept_en(~test_mode), .clear(rd_hit[SLOT_DATA]),
    .ready(rx_ready), .overrun(overrun), .hold(rx_hold)
  );

  uart_rate_select u_rate (
    .clk(clk), .rst(rst), .alt(alt_baud), .code(rate_code), .rate_bps(rate_bps)
  );

  // Written registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_code <= '0;
      cmd_reg   <= '0;
      aux_reg   <= '0;
    end else begin
      if (wr_hit[SLOT_STATUS])  rate_code <= wdata[3:0];
      if (wr_hit[SLOT_BAUDTGL]) cmd_reg   <= wdata;
      if (wr_hit[SLOT_TESTTGL]) aux_reg   <= wdata;
    end
  end

  // Transmit hand-off
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      tx_data <= '0;
    end else begin
      tx_load <= wr_hit[SLOT_DATA] & ~test_mode;
      if (wr_hit[SLOT_DATA] && !test_mode) tx_data <= wdata;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_RXRDY] = rx_ready;
    status[ST_OVR]   = overrun;
    status[ST_ALT]   = alt_baud;
    status[ST_TEST]  = test_mode;
  end

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_any) begin
      case (slot)
        SLOT_STATUS:  rdata <= status;
        SLOT_BAUDTGL: rdata <= {{(DW-4){1'b0}}, rate_code};
        SLOT_DATA:    rdata <= rx_hold;
        SLOT_TESTTGL: rdata <= aux_reg;
        SLOT_CMDRB:   rdata <= cmd_reg;
        default:      rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              rx_valid,
  input logic              tx_load,
  input logic              alt_baud,
  input logic              test_mode,
  input logic              rx_ready
);
  logic rd_seen;
  logic rd_edge;

  always_ff @(posedge clk) begin
    if (rst) rd_seen <= 1'b0;
    else     rd_seen <= cs & rd;
  end
  assign rd_edge = cs & rd & ~rd_seen;

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!alt_baud && !test_mode && !rx_ready && !tx_load));

  p_alt_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_edge && addr[2:0] == 3'd1) |=> (alt_baud != $past(alt_baud)));

  p_alt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(rd_edge && addr[2:0] == 3'd1) |=> $stable(alt_baud));

  p_test_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_edge && addr[2:0] == 3'd3) |=> (test_mode != $past(test_mode)));

  p_test_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(rd_edge && addr[2:0] == 3'd3) |=> $stable(test_mode));

  p_test_no_tx_r6: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> !tx_load);

  p_test_no_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !rx_ready) |=> !rx_ready);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_edge && addr[2:0] == 3'd2 && !rx_valid) |=> !rx_ready);
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .rx_valid(rx_valid),
  .tx_load(tx_load), .alt_baud(alt_baud), .test_mode(test_mode), .rx_ready(rx_ready)
);

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs, rd, wr, rx_valid;
  logic [4:0]  addr;
  logic [7:0]  wdata, rx_data, rdata, tx_data;
  logic        tx_load, alt_baud, test_mode, rx_ready;
  logic [15:0] rate_bps;

  int checks = 0;
  int failures = 0;
  logic [7:0] got;
  logic       got_load;

  always #2.5 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data), .tx_load(tx_load),
    .tx_data(tx_data), .alt_baud(alt_baud), .test_mode(test_mode),
    .rx_ready(rx_ready), .rate_bps(rate_bps)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [4:0] a, input int hold);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    for (int i = 0; i < hold; i++) @(negedge clk);
    got = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    got_load = tx_load;
    for (int i = 1; i < hold; i++) @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(alt_baud, 0, "R11 alt after reset");
    check(test_mode, 0, "R11 test after reset");
    check(rx_ready, 0, "R11 rx_ready after reset");
    check(rate_bps, 50, "R4 rate code0 primary");
    do_read(5'h00, 1);
    check(got, 8'h00, "R10 status after reset");
  endtask

  task automatic t_mirror();
    do_write(5'h18, 8'h0C, 1);
    do_read(5'h09, 1);
    check(got, 8'h0C, "R3 rate code readback via mirror");
    check(alt_baud, 1, "R1 mirror read toggles alt");
    settle();
    check(rate_bps, 28800, "R4 code12 alternate");
    do_read(5'h11, 1);
    check(alt_baud, 0, "R1 second mirror toggles back");
    settle();
    check(rate_bps, 9600, "R4 code12 primary");
    @(negedge clk); cs = 1'b0; rd = 1'b1; addr = 5'h01;
    @(negedge clk); @(negedge clk); rd = 1'b0;
    check(alt_baud, 0, "R1 read with cs low ignored");
    do_write(5'h1A, 8'h9E, 1);
    check(got_load, 1, "R7 tx via mirror");
    check(tx_data, 8'h9E, "R7 tx data");
  endtask

  task automatic t_strobe();
    do_read(5'h01, 4);
    check(alt_baud, 1, "R2 held read toggles once");
    do_read(5'h01, 1);
    check(alt_baud, 0, "R2 next read toggles");
    do_write(5'h01, 8'hA5, 3);
    check(alt_baud, 0, "R3 write cmd no toggle");
    do_read(5'h04, 1);
    check(got, 8'hA5, "R12 cmd readback");
    do_read(5'h05, 1);
    check(got, 8'h00, "R12 slot5 zero");
    do_read(5'h07, 1);
    check(got, 8'h00, "R12 slot7 zero");
  endtask

  task automatic t_rate_shared();
    do_write(5'h00, 8'h0E, 1);
    settle();
    check(rate_bps, 19200, "R4 code14 primary");
    do_read(5'h01, 1); settle();
    check(rate_bps, 19200, "R4 code14 alternate");
    do_write(5'h00, 8'h0F, 1); settle();
    check(rate_bps, 38400, "R4 code15 alternate");
    do_read(5'h00, 1);
    check(got, 8'h04, "R10 status alt bit");
    do_read(5'h01, 1); settle();
    check(rate_bps, 38400, "R4 code15 primary");
  endtask

  task automatic t_test();
    do_write(5'h03, 8'h3C, 1);
    check(test_mode, 0, "R5 aux write no toggle");
    do_read(5'h03, 1);
    check(got, 8'h3C, "R5 aux readback");
    check(test_mode, 1, "R5 read enters test");
    push_rx(8'h66);
    check(rx_ready, 0, "R6 rx ignored in test");
    do_write(5'h02, 8'h11, 1);
    check(got_load, 0, "R6 tx blocked in test");
    do_read(5'h00, 1);
    check(got, 8'h08, "R10 status test bit");
    do_write(5'h0B, 8'h5A, 1);
    check(test_mode, 1, "R5 aux mirror write keeps test");
    do_read(5'h1B, 1);
    check(got, 8'h5A, "R5 aux updated");
    check(test_mode, 0, "R5 second read leaves test");
    do_write(5'h02, 8'h77, 1);
    check(got_load, 1, "R7 tx after test");
    check(tx_data, 8'h77, "R7 tx data after test");
  endtask

  task automatic t_rx();
    push_rx(8'h41);
    check(rx_ready, 1, "R9 byte arrival sets ready");
    do_read(5'h00, 1);
    check(got, 8'h01, "R10 status ready");
    push_rx(8'h42);
    do_read(5'h00, 1);
    check(got, 8'h03, "R9 overrun");
    do_read(5'h02, 1);
    check(got, 8'h42, "R9 newer byte kept");
    check(rx_ready, 0, "R8 read clears ready");
    do_read(5'h00, 1);
    check(got, 8'h00, "R8 overrun cleared");
    push_rx(8'h10);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 5'h02; rx_valid = 1'b1; rx_data = 8'h20;
    @(negedge clk);
    got = rdata; cs = 1'b0; rd = 1'b0; rx_valid = 1'b0;
    check(got, 8'h10, "R8 same-cycle read returns older");
    check(rx_ready, 1, "R8 same-cycle arrival keeps ready");
    do_read(5'h02, 1);
    check(got, 8'h20, "R8 newer byte after collision");
  endtask

  task automatic t_reset_mid();
    do_read(5'h01, 1);
    do_read(5'h03, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check(alt_baud, 0, "R11 alt cleared");
    check(test_mode, 0, "R11 test cleared");
    check(rx_ready, 0, "R11 ready cleared");
    check(rate_bps, 50, "R11 rate back to code0");
    do_read(5'h04, 1);
    check(got, 8'h00, "R11 cmd cleared");
  endtask

  initial begin
    rst = 1'b1; cs = 0; rd = 0; wr = 0; addr = '0; wdata = '0; rx_valid = 0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mirror();
    t_strobe();
    t_rate_shared();
    t_test();
    t_rx();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule